// File: doc/BRIEF.md
# Cycle-Counted Serial Byte Receiver

This block takes a single-wire, half-duplex serial line and turns it into bytes. It has no oversampling front end. A two-stage synchronizer feeds one counter that measures bit periods in system clocks. When the receiver is idle and enabled, it watches for the line to fall. Half a bit period later it checks the line again and drops pulses that are too short to be a start bit. It then samples eight data bits, least significant first, each at the centre of its bit window, and reads one stop bit after them.

Each byte it receives is also added into an 8-bit checksum with end-around carry, which covers every byte of a frame. A frame-clear input empties the checksum between frames. A byte whose stop bit reads low still goes out, and a flag marks it as badly framed. Driving the line, choosing the line direction and parsing packets are the job of the surrounding logic.

Top module: `sline_rx`

## Requirements
- R1: After synchronous reset, rx_valid, frame_err, rx_data and csum are all zero.
- R2: A reception starts only when all three hold: the receiver is idle, en is high, and the synchronised line falls from 1 to 0. While en is low, traffic on rx_in produces no byte and leaves csum unchanged.
- R3: The start bit is checked again floor(CLKS_PER_BIT/2) clocks after the falling edge is detected. If the line is high at that point, the attempt is dropped: no rx_valid, and csum does not change.
- R4: Data bit 0 is sampled floor(CLKS_PER_BIT/2)+CLKS_PER_BIT clocks after start detection, which is between 1 and 2 bit times. Each later bit is sampled exactly CLKS_PER_BIT clocks after the one before it. Bits arrive least significant first, so the first bit received is rx_data[0].
- R5: The stop bit is sampled CLKS_PER_BIT clocks after data bit 7. rx_valid is then high for exactly one cycle, with rx_data, frame_err and csum all updated at the same clock edge. Call the first rising clock edge that registers the low start level on rx_in edge 0. rx_valid goes high just after edge floor(CLKS_PER_BIT/2)+9*CLKS_PER_BIT+2.
- R6: frame_err is 1 when the sampled stop bit was 0 and 0 when it was 1. It is updated with every delivered byte, and a byte with a low stop bit is still delivered.
- R7: On each delivered byte, csum becomes the low 8 bits of (csum + byte), plus 1 if that addition carried out of bit 7. For example, 0xF0 then 0x20 gives 0x11.
- R8: A one-cycle pulse on frame_clr sets csum to 0 on the next edge. If a byte is delivered on that same edge, csum becomes that byte.
- R9: After the stop bit the receiver waits for the next start. Bytes sent back to back with a single stop bit are all received. A line that stays low after a bad stop bit does not start a new byte until it goes high and then falls again.
- R10: en only gates the start of a reception. If en drops while a byte is being received, that byte still completes and is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Allows a new reception to start |
| frame_clr | input | 1 | Clears the frame checksum |
| rx_in | input | 1 | Asynchronous serial line; idles high |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new byte |
| csum | output | 8 | End-around-carry checksum of the frame |
| frame_err | output | 1 | Stop bit of the last byte was low |

## Verification
Each result is due a fixed number of cycles after its stimulus. A byte, with its frame_err and checksum, arrives floor(CLKS_PER_BIT/2)+9*CLKS_PER_BIT+2 edges after the start level is first registered. A cleared checksum reads zero one edge after the frame_clr pulse. A rejected glitch or a disabled reception shows up as no strobe at all. The driver records the cycle number at which it lowers the line and puts the expected byte, flag, checksum and due cycle into a queue. The monitor samples on the falling clock edge, matches each strobe against the head of the queue, and compares the cycle it sees with the cycle that was expected. A strobe that arrives when the queue is empty is a failure, and so is an entry still waiting in the queue at the end.

// File: rtl/sline_rx_pkg.sv
package sline_rx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              bad_stop;
    } rx_byte_t;

    // 8-bit add with the carry-out folded back into bit 0
    function automatic logic [BYTE_W-1:0] csum_fold(
        input logic [BYTE_W-1:0] acc,
        input logic [BYTE_W-1:0] val
    );
        logic [BYTE_W:0] wide;
        wide = {1'b0, acc} + {1'b0, val};
        return wide[BYTE_W-1:0] + {{(BYTE_W-1){1'b0}}, wide[BYTE_W]};
    endfunction

endpackage

// File: rtl/sline_sync.sv
module sline_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= RST_VAL;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/sline_bit_timer.sv
module sline_bit_timer #(
    parameter int CLKS_PER_BIT = 76
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic half_sel,
    output logic tick
);
    localparam int HALF_BIT = CLKS_PER_BIT / 2;
    localparam int CNT_W    = $clog2(CLKS_PER_BIT);
    localparam logic [CNT_W-1:0] FULL_LIM = CNT_W'(CLKS_PER_BIT - 1);
    localparam logic [CNT_W-1:0] HALF_LIM = CNT_W'(HALF_BIT - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    assign lim  = half_sel ? HALF_LIM : FULL_LIM;
    assign tick = !hold && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || hold) cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sline_csum.sv
module sline_csum
    import sline_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              add,
    input  logic [BYTE_W-1:0] val,
    output logic [BYTE_W-1:0] sum
);
    logic [BYTE_W-1:0] base;

    assign base = clr ? '0 : sum;

    always_ff @(posedge clk) begin
        if (rst)      sum <= '0;
        else if (add) sum <= csum_fold(base, val);
        else if (clr) sum <= '0;
    end
endmodule

// File: rtl/sline_rx.sv
module sline_rx
    import sline_rx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 76,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              frame_clr,
    input  logic              rx_in,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] csum,
    output logic              frame_err
);
    localparam int IDX_W = $clog2(BYTE_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

    rx_state_e         st;
    logic              line_s;
    logic              line_q;
    logic              fall;
    logic              tick;
    logic [IDX_W-1:0]  bit_idx;
    logic [BYTE_W-1:0] shreg;
    logic              byte_done;
    rx_byte_t          out_q;

    sline_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (rx_in),
        .q_sync  (line_s)
    );

    sline_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .hold     (st == RX_IDLE),
        .half_sel (st == RX_START),
        .tick     (tick)
    );

    assign fall      = line_q && !line_s;
    assign byte_done = (st == RX_STOP) && tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= RX_IDLE;
            line_q   <= 1'b1;
            bit_idx  <= '0;
            shreg    <= '0;
            out_q    <= '0;
            rx_valid <= 1'b0;
        end else begin
            line_q   <= line_s;
            rx_valid <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (en && fall) st <= RX_START;
                end
                RX_START: begin
                    if (tick) begin
                        if (line_s) st <= RX_IDLE;
                        else begin
                            st      <= RX_DATA;
                            bit_idx <= '0;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        shreg <= {line_s, shreg[BYTE_W-1:1]};
                        if (bit_idx == LAST_IDX) st <= RX_STOP;
                        else bit_idx <= bit_idx + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        out_q.data     <= shreg;
                        out_q.bad_stop <= !line_s;
                        rx_valid       <= 1'b1;
                        st             <= RX_IDLE;
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    sline_csum u_csum (
        .clk (clk),
        .rst (rst),
        .clr (frame_clr),
        .add (byte_done),
        .val (shreg),
        .sum (csum)
    );

    assign rx_data   = out_q.data;
    assign frame_err = out_q.bad_stop;
endmodule

// File: rtl/sline_rx_chk.sv
module sline_rx_chk
    import sline_rx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 76
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              frame_clr,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic [BYTE_W-1:0] csum,
    input  rx_state_e         st,
    input  logic              tick,
    input  logic [$clog2(BYTE_W)-1:0] bit_idx
);
    int unsigned since;

    always_ff @(posedge clk) begin
        if (rst || st == RX_IDLE) since <= 0;
        else                      since <= since + 1;
    end

    AST_FIRST_SAMPLE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (st == RX_DATA && tick && bit_idx == '0) |->
            (since >= CLKS_PER_BIT - 1 && since <= 2*CLKS_PER_BIT - 1)); // R4

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R5

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        frame_clr |=> (rx_valid || csum == '0)); // R8

    AST_CSUM_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !frame_clr |=> (rx_valid || $stable(csum))); // R7

    AST_CSUM_FOLDS: assert property (@(posedge clk) disable iff (rst)
        !frame_clr |=> (!rx_valid || csum == csum_fold($past(csum), rx_data))); // R7

    AST_EN_GATES_START: assert property (@(posedge clk) disable iff (rst)
        (!en && st == RX_IDLE) |=> (st == RX_IDLE)); // R2
endmodule

bind sline_rx sline_rx_chk #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .frame_clr (frame_clr),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .csum      (csum),
    .st        (st),
    .tick      (tick),
    .bit_idx   (bit_idx)
);

// File: tb/test_sline_rx.sv
module test_sline_rx;
    import sline_rx_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int BIT        = 16;
    localparam int HALF       = BIT / 2;
    localparam int LATENCY    = 3 + HALF + 9*BIT;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b1;
    logic       frame_clr = 1'b0;
    logic       rx_in = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic [7:0] csum;
    logic       frame_err;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int n_valid = 0;
    logic [7:0] model_sum = 8'h00;

    logic [7:0] q_data[$];
    logic       q_err[$];
    logic [7:0] q_sum[$];
    int         q_due[$];

    sline_rx #(.CLKS_PER_BIT(BIT)) i_sline_rx (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .frame_clr (frame_clr),
        .rx_in     (rx_in),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .csum      (csum),
        .frame_err (frame_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] fold(input logic [7:0] a, input logic [7:0] b);
        int s;
        s = int'(a) + int'(b);
        if (s > 255) s = s - 256 + 1;
        return s[7:0];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Driver: one start bit, eight data bits LSB first, one stop bit
    task automatic send_byte(input logic [7:0] d, input bit stop_hi,
                             input bit expect_it, input int hold_low, input int gap);
        @(negedge clk);
        if (expect_it) begin
            model_sum = fold(model_sum, d);
            q_data.push_back(d);
            q_err.push_back(!stop_hi);
            q_sum.push_back(model_sum);
            q_due.push_back(cyc + LATENCY);
        end
        rx_in = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_in = d[i];
            repeat (BIT) @(negedge clk);
        end
        rx_in = stop_hi;
        repeat (BIT + hold_low) @(negedge clk);
        rx_in = 1'b1;
        repeat (gap) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        frame_clr = 1'b1;
        model_sum = 8'h00;
        @(negedge clk);
        frame_clr = 1'b0;
        check(csum == 8'h00, "R8", "checksum after clear", csum, 0);
    endtask

    // Monitor: compares every strobe with the head of the scoreboard
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            n_valid++;
            if (q_data.size() == 0) begin
                check(1'b0, "R2", "unexpected byte", rx_data, 0);
            end else begin
                logic [7:0] ed;
                logic       ee;
                logic [7:0] es;
                int         eu;
                ed = q_data.pop_front();
                ee = q_err.pop_front();
                es = q_sum.pop_front();
                eu = q_due.pop_front();
                check(rx_data == ed, "R4", "data", rx_data, ed);
                check(frame_err == ee, "R6", "frame_err", frame_err, ee);
                check(csum == es, "R7", "checksum", csum, es);
                check(cyc == eu, "R5", "strobe cycle", cyc, eu);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        int nv;
        logic [7:0] s0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rx_valid == 1'b0, "R1", "rx_valid after reset", rx_valid, 0);
        check(frame_err == 1'b0, "R1", "frame_err after reset", frame_err, 0);
        check(rx_data == 8'h00, "R1", "rx_data after reset", rx_data, 0);
        check(csum == 8'h00, "R1", "csum after reset", csum, 0);

        // Basic patterns, with a gap between bytes
        send_byte(8'hA5, 1'b1, 1'b1, 0, 5);
        send_byte(8'h3C, 1'b1, 1'b1, 0, 7);
        send_byte(8'h00, 1'b1, 1'b1, 0, 3);
        send_byte(8'hFF, 1'b1, 1'b1, 0, 3);
        pulse_clear();

        // Carry folding: 0xF0 + 0x20 -> 0x11 (R7)
        send_byte(8'hF0, 1'b1, 1'b1, 0, 4);
        send_byte(8'h20, 1'b1, 1'b1, 0, 4);
        repeat (4) @(negedge clk);
        check(csum == 8'h11, "R7", "folded carry", csum, 8'h11);
        pulse_clear();

        // Back to back bytes with a single stop bit (R9)
        send_byte(8'h81, 1'b1, 1'b1, 0, 0);
        send_byte(8'h7E, 1'b1, 1'b1, 0, 0);
        send_byte(8'h96, 1'b1, 1'b1, 0, 6);

        // Short low glitch is rejected (R3)
        nv = n_valid;
        s0 = csum;
        @(negedge clk);
        rx_in = 1'b0;
        repeat (3) @(negedge clk);
        rx_in = 1'b1;
        repeat (3*BIT) @(negedge clk);
        check(n_valid == nv, "R3", "strobes after glitch", n_valid, nv);
        check(csum == s0, "R3", "csum after glitch", csum, s0);

        // Disabled receiver ignores a whole byte (R2)
        en = 1'b0;
        send_byte(8'h5A, 1'b1, 1'b0, 0, 2*BIT);
        check(n_valid == nv, "R2", "strobes while disabled", n_valid, nv);
        check(csum == s0, "R2", "csum while disabled", csum, s0);
        en = 1'b1;

        // Bad stop bit, then the line stays low for a while (R6, R9)
        send_byte(8'hC3, 1'b0, 1'b1, 3*BIT, 2*BIT);
        check(n_valid == nv + 1, "R9", "strobes after held-low line", n_valid, nv + 1);
        send_byte(8'h42, 1'b1, 1'b1, 0, 4);

        // en drops mid-byte; the byte still completes (R10)
        fork
            send_byte(8'h19, 1'b1, 1'b1, 0, 4);
            begin
                repeat (3*BIT) @(negedge clk);
                en = 1'b0;
            end
        join
        repeat (4) @(negedge clk);
        check(n_valid == nv + 3, "R10", "byte finished after en drop", n_valid, nv + 3);
        en = 1'b1;

        repeat (2*BIT) @(negedge clk);
        check(q_data.size() == 0, "R9", "pending expected bytes", q_data.size(), 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule